// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Refresh Sequencing

This block drives a 16-bit DRAM that may sit in any of four external address areas: areas 2, 3, 4 and 5. Each area has its own enable bit. The row and column addresses share one set of pins, and the column width can be set to 8, 9 or 10 bits. There is one row strobe (`ras_n`) and one write strobe (`we_n`). Byte lanes are selected with two column strobes: `ucas_n` for the upper byte and `lcas_n` for the lower byte. After an access the row stays open. A later access to the same area and row runs in fast-page form: only the column strobes toggle. Any other DRAM access first closes the row through a precharge state.

Refresh has two sources:
- An internal interval counter raises a refresh request. The controller serves it with a CAS-before-RAS cycle at the next idle state, ahead of any waiting access.
- An external level request (`selfref_req`) holds the DRAM in self-refresh until the level drops.

Requests arrive on a valid/ready channel. `req_valid` may rise at any time. Once raised, it must stay high with stable address, write flag, byte enables and write data until a clock edge on which `req_ready` is also high. That edge is the acceptance.

Back-pressure works as follows. `req_ready` is low whenever the sequencer is busy, a refresh is pending, or self-refresh is requested. Completion is a one-state `done` pulse. For a read, `rd_data` is valid while `done` is high.

Top module: `dram_page_ctrl`

## Requirements
- R1: A request is a DRAM access only when address bits [23:21] give area 2–5 and `dram_en[area-2]` is 1. Any other accepted request raises `done` in the first state after acceptance and moves no strobe.
- R2: Let CW be 8, 9 or 10 for `col_sel` = 0, 1 or 2 (3 acts as 10). In the row state `dram_a` carries address bits [CW+10:CW+1]. In the column states it carries bits [CW:1], zero-extended to 10 bits.
- R3: In the column states, `ucas_n` is low exactly when `req_be[1]` was 1 and `lcas_n` exactly when `req_be[0]` was 1. For a write, `we_n` is low and `dq_oe` is high, with `dq_out` equal to the write data. `we_n` is low only while `ras_n` is low.
- R4: An access with no row open raises `done` in the third state after acceptance. `done` lasts one state. For a read, `rd_data` is the `dq_in` value from the first column state.
- R5: An access to the area and row that are already open runs in fast-page form. `ras_n` stays low, there is no precharge and no new row state, and `done` rises in the second state after acceptance.
- R6: An access to a different row, or to a different DRAM area, while a row is open makes `ras_n` rise for one precharge state with all strobes high. A new row state follows, and `done` rises in the fourth state after acceptance.
- R7: In a CAS-before-RAS refresh, any open row is first precharged. Both column strobes then fall one state before `ras_n` falls. The cycle ends with a precharge state and leaves no row open.
- R8: With `refr_interval` = N > 0, a refresh is requested every N clock cycles. N = 0 turns periodic refresh off. While a refresh is pending, `req_ready` is low, so the refresh is served before any new access.
- R9: While `selfref_req` is high at an idle point, any open row is precharged. Both column strobes then fall, then `ras_n` falls, and all three stay low and `req_ready` stays low while the request is held. When the request drops, one precharge state with all strobes high follows, then idle with no row open.
- R10: `req_ready` is high only in the idle state. Out of reset the strobes and `we_n` are high, `dq_oe` and `done` are low, and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted on this edge if valid |
| req_addr | input | 24 | Byte address; bits [23:21] select the area |
| req_we | input | 1 | 1 = write, 0 = read |
| req_be | input | 2 | Byte enables: bit 1 upper byte, bit 0 lower byte |
| req_wdata | input | 16 | Write data |
| done | output | 1 | One-state completion pulse |
| rd_data | output | 16 | Read data, valid with `done` |
| dram_en | input | 4 | Bit i enables DRAM mode for area i+2 |
| col_sel | input | 2 | Column width select: 0 = 8, 1 = 9, 2 or 3 = 10 bits |
| refr_interval | input | 12 | Refresh period in clock cycles; 0 = off |
| selfref_req | input | 1 | Level request to hold self-refresh |
| dram_a | output | 10 | Multiplexed row/column address |
| ras_n | output | 1 | Row strobe, active low |
| ucas_n | output | 1 | Upper-byte column strobe, active low |
| lcas_n | output | 1 | Lower-byte column strobe, active low |
| we_n | output | 1 | Write strobe, active low |
| dq_out | output | 16 | Write data to DRAM |
| dq_oe | output | 1 | Data output enable |
| dq_in | input | 16 | Read data from DRAM |

## Verification
The hardest case to reach from the ports is a refresh request that becomes pending while an access is already waiting with `req_valid` high. The sequencer must hold that access back, run the CAS-before-RAS cycle, and then reopen the row instead of treating the access as a page hit.

The bench sets a short refresh interval and issues a long run of back-to-back same-row reads. The refresh must land somewhere inside that run. The bench then checks three things:
- every read returns the data its row and column imply;
- at least one refresh with the column-before-row strobe order took place;
- no strobe-order violation was seen.

// File: rtl/dram_pkg.sv
package dram_pkg;
  localparam int NUM_CW       = 3;   // selectable column widths
  localparam int CW_MIN       = 8;   // narrowest column width
  localparam int AREA_W       = 3;
  localparam int DRAM_AREA_LO = 2;
  localparam int DRAM_AREAS   = 4;

  typedef enum logic [3:0] {
    ST_IDLE, ST_SKIP, ST_PRE, ST_ROW, ST_COL1, ST_COL2,
    ST_CBR1, ST_CBR2, ST_SELF1, ST_SELF2
  } dram_state_e;

  typedef enum logic [1:0] {GO_NONE, GO_ACC, GO_CBR, GO_SELF} pre_tgt_e;

  function automatic logic area_is_dram(input logic [AREA_W-1:0] area,
                                        input logic [DRAM_AREAS-1:0] en);
    logic [AREA_W-1:0] rel;
    rel = area - AREA_W'(DRAM_AREA_LO);
    return (area >= AREA_W'(DRAM_AREA_LO)) &&
           (area < AREA_W'(DRAM_AREA_LO + DRAM_AREAS)) && en[rel[1:0]];
  endfunction
endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] interval,
  input  logic             clear,
  output logic             pend
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pend  <= 1'b0;
    end else if (interval == '0) begin
      cnt_q <= '0;
      pend  <= 1'b0;
    end else begin
      if (clear) pend <= 1'b0;
      if (cnt_q >= interval - 1'b1) begin
        cnt_q <= '0;
        pend  <= 1'b1;   // a new tick wins over a same-cycle clear
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dram_addr_mux.sv
module dram_addr_mux
  import dram_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int AW     = 10
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        col_sel,
  output logic [AW-1:0]     row,
  output logic [AW-1:0]     col,
  output logic [AREA_W-1:0] area
);
  logic [AW-1:0] row_c [NUM_CW];
  logic [AW-1:0] col_c [NUM_CW];
  logic [1:0]    idx;

  for (genvar g = 0; g < NUM_CW; g++) begin : g_cw
    localparam int CW = CW_MIN + g;
    assign col_c[g] = AW'(addr[CW:1]);
    assign row_c[g] = addr[CW+AW:CW+1];
  end

  assign idx  = (col_sel >= 2'(NUM_CW - 1)) ? 2'(NUM_CW - 1) : col_sel;
  assign row  = row_c[idx];
  assign col  = col_c[idx];
  assign area = addr[ADDR_W-1 -: AREA_W];
endmodule

// File: rtl/dram_seq.sv
module dram_seq
  import dram_pkg::*;
#(
  parameter int AW = 10,
  parameter int DW = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_we,
  input  logic [1:0]            req_be,
  input  logic [DW-1:0]         req_wdata,
  input  logic [AW-1:0]         in_row,
  input  logic [AW-1:0]         in_col,
  input  logic [AREA_W-1:0]     in_area,
  input  logic [DRAM_AREAS-1:0] dram_en,
  input  logic                  refr_pend,
  output logic                  refr_clear,
  input  logic                  selfref_req,
  output logic                  done,
  output logic [DW-1:0]         rd_data,
  output logic [AW-1:0]         dram_a,
  output logic                  ras_n,
  output logic                  ucas_n,
  output logic                  lcas_n,
  output logic                  we_n,
  output logic [DW-1:0]         dq_out,
  output logic                  dq_oe,
  input  logic [DW-1:0]         dq_in,
  output dram_state_e           state
);
  dram_state_e       st_q;
  pre_tgt_e          tgt_q;
  logic              open_q;
  logic [AREA_W-1:0] open_area_q;
  logic [AW-1:0]     open_row_q, row_q, col_q;
  logic [1:0]        be_q;
  logic              we_q;
  logic [DW-1:0]     wdata_q, rd_q;
  logic              hit, in_col_st, in_cbr_st;

  assign hit = open_q && (in_area == open_area_q) && (in_row == open_row_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;  tgt_q <= GO_NONE;  open_q <= 1'b0;
      open_area_q <= '0;  open_row_q <= '0;  row_q <= '0;  col_q <= '0;
      be_q <= '0;  we_q <= 1'b0;  wdata_q <= '0;  rd_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (selfref_req) begin
            st_q <= open_q ? ST_PRE : ST_SELF1;  tgt_q <= GO_SELF;
          end else if (refr_pend) begin
            st_q <= open_q ? ST_PRE : ST_CBR1;   tgt_q <= GO_CBR;
          end else if (req_valid) begin
            row_q <= in_row;  col_q <= in_col;  be_q <= req_be;
            we_q <= req_we;   wdata_q <= req_wdata;  tgt_q <= GO_ACC;
            if (!area_is_dram(in_area, dram_en)) st_q <= ST_SKIP;
            else if (hit)                         st_q <= ST_COL1;
            else begin
              st_q <= open_q ? ST_PRE : ST_ROW;
              open_area_q <= in_area;
            end
          end
        end
        ST_PRE: begin
          open_q <= 1'b0;
          case (tgt_q)
            GO_ACC:  st_q <= ST_ROW;
            GO_CBR:  st_q <= ST_CBR1;
            GO_SELF: st_q <= ST_SELF1;
            default: st_q <= ST_IDLE;
          endcase
        end
        ST_ROW: begin
          open_q <= 1'b1;  open_row_q <= row_q;  st_q <= ST_COL1;
        end
        ST_COL1: begin rd_q <= dq_in;  st_q <= ST_COL2; end
        ST_CBR1:  st_q <= ST_CBR2;
        ST_CBR2:  begin st_q <= ST_PRE;  tgt_q <= GO_NONE; end
        ST_SELF1: st_q <= ST_SELF2;
        ST_SELF2: if (!selfref_req) begin st_q <= ST_PRE;  tgt_q <= GO_NONE; end
        default:  st_q <= ST_IDLE;   // ST_COL2, ST_SKIP
      endcase
    end
  end

  assign in_col_st  = (st_q == ST_COL1) || (st_q == ST_COL2);
  assign in_cbr_st  = (st_q == ST_CBR1) || (st_q == ST_CBR2) ||
                      (st_q == ST_SELF1) || (st_q == ST_SELF2);
  assign refr_clear = (st_q == ST_CBR2) || ((st_q == ST_SELF2) && !selfref_req);

  always_comb begin
    ras_n = 1'b1;
    case (st_q)
      ST_ROW, ST_COL1, ST_COL2, ST_CBR2, ST_SELF2: ras_n = 1'b0;
      ST_IDLE, ST_SKIP:                            ras_n = !open_q;
      default:                                     ras_n = 1'b1;
    endcase
  end

  assign ucas_n    = !((in_col_st && be_q[1]) || in_cbr_st);
  assign lcas_n    = !((in_col_st && be_q[0]) || in_cbr_st);
  assign we_n      = !(in_col_st && we_q);
  assign dq_oe     = in_col_st && we_q;
  assign dq_out    = wdata_q;
  assign dram_a    = in_col_st ? col_q : row_q;
  assign done      = (st_q == ST_COL2) || (st_q == ST_SKIP);
  assign rd_data   = rd_q;
  assign req_ready = (st_q == ST_IDLE) && !refr_pend && !selfref_req;
  assign state     = st_q;
endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl
  import dram_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int AW     = 10,
  parameter int DW     = 16,
  parameter int CNT_W  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_we,
  input  logic [1:0]        req_be,
  input  logic [DW-1:0]     req_wdata,
  output logic              done,
  output logic [DW-1:0]     rd_data,
  input  logic [3:0]        dram_en,
  input  logic [1:0]        col_sel,
  input  logic [CNT_W-1:0]  refr_interval,
  input  logic              selfref_req,
  output logic [AW-1:0]     dram_a,
  output logic              ras_n,
  output logic              ucas_n,
  output logic              lcas_n,
  output logic              we_n,
  output logic [DW-1:0]     dq_out,
  output logic              dq_oe,
  input  logic [DW-1:0]     dq_in
);
  logic [AW-1:0]     mux_row, mux_col;
  logic [AREA_W-1:0] mux_area;
  logic              refr_pend, refr_clear;
  dram_state_e       seq_state;

  dram_addr_mux #(.ADDR_W(ADDR_W), .AW(AW)) u_mux (
    .addr(req_addr), .col_sel(col_sel),
    .row(mux_row), .col(mux_col), .area(mux_area)
  );

  dram_refresh_timer #(.CNT_W(CNT_W)) u_refr (
    .clk(clk), .rst_n(rst_n), .interval(refr_interval),
    .clear(refr_clear), .pend(refr_pend)
  );

  dram_seq #(.AW(AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_be(req_be), .req_wdata(req_wdata),
    .in_row(mux_row), .in_col(mux_col), .in_area(mux_area), .dram_en(dram_en),
    .refr_pend(refr_pend), .refr_clear(refr_clear), .selfref_req(selfref_req),
    .done(done), .rd_data(rd_data), .dram_a(dram_a), .ras_n(ras_n),
    .ucas_n(ucas_n), .lcas_n(lcas_n), .we_n(we_n), .dq_out(dq_out),
    .dq_oe(dq_oe), .dq_in(dq_in), .state(seq_state)
  );
endmodule

// File: rtl/dram_page_ctrl_chk.sv
module dram_page_ctrl_chk
  import dram_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        req_ready,
  input logic        done,
  input logic        ras_n,
  input logic        ucas_n,
  input logic        lcas_n,
  input logic        we_n,
  input logic        dq_oe,
  input logic        selfref_req,
  input logic        refr_pend,
  input dram_state_e st
);
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_READY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (ucas_n && lcas_n && we_n && !dq_oe)); // R10
  AST_REFRESH_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    refr_pend |-> !req_ready); // R8
  AST_CBR_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ras_n) && !ucas_n && !lcas_n) |-> $past(!ucas_n && !lcas_n)); // R7
  AST_PRE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ras_n) |-> (ucas_n && lcas_n && we_n)); // R6
  AST_WE_UNDER_RAS: assert property (@(posedge clk) disable iff (!rst_n)
    !we_n |-> (!ras_n && dq_oe)); // R3
  AST_SELF_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SELF2 && selfref_req) |=> (!ras_n && !ucas_n && !lcas_n)); // R9
endmodule

bind dram_page_ctrl dram_page_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
  .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n), .we_n(we_n),
  .dq_oe(dq_oe), .selfref_req(selfref_req), .refr_pend(refr_pend),
  .st(seq_state)
);

// File: tb/tb_dram_page_ctrl.sv
`timescale 1ns/1ps
module tb_dram_page_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        req_valid = 1'b0, req_ready, req_we = 1'b0;
  logic [23:0] req_addr = '0;
  logic [1:0]  req_be = 2'b11;
  logic [15:0] req_wdata = '0, rd_data, dq_out, dq_in;
  logic        done, ras_n, ucas_n, lcas_n, we_n, dq_oe;
  logic [3:0]  dram_en = 4'b1011;
  logic [1:0]  col_sel = 2'd0;
  logic [11:0] refr_interval = '0;
  logic        selfref_req = 1'b0;
  logic [9:0]  dram_a;

  dram_page_ctrl dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_be(req_be), .req_wdata(req_wdata),
    .done(done), .rd_data(rd_data), .dram_en(dram_en), .col_sel(col_sel),
    .refr_interval(refr_interval), .selfref_req(selfref_req), .dram_a(dram_a),
    .ras_n(ras_n), .ucas_n(ucas_n), .lcas_n(lcas_n), .we_n(we_n),
    .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  int ras_fall = 0, ras_rise = 0, cbr_cnt = 0, cbr_bad = 0;
  logic prev_ras = 1'b1, prev_u = 1'b1, prev_l = 1'b1;
  logic [9:0]  row_cap = '0;
  logic        wr_seen = 1'b0, wr_u = 1'b0, wr_l = 1'b0;
  logic [15:0] wr_data = '0;

  // DRAM model: the row latched on the falling row strobe, the column from the pins
  assign dq_in = {row_cap[5:0], dram_a};

  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_ras && !ras_n) begin
        ras_fall++;
        row_cap = dram_a;
        if (!ucas_n && !lcas_n) begin
          if (!prev_u && !prev_l) cbr_cnt++; else cbr_bad++;
        end
      end
      if (!prev_ras && ras_n) ras_rise++;
      if (!we_n) begin
        wr_seen = 1'b1; wr_data = dq_out; wr_u = !ucas_n; wr_l = !lcas_n;
      end
    end
    prev_ras = ras_n; prev_u = ucas_n; prev_l = lcas_n;
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_rd(input logic [23:0] a, input int sel);
    int cw;
    logic [9:0] col, row;
    cw  = (sel == 0) ? 8 : (sel == 1) ? 9 : 10;
    col = 10'((a >> 1) & ((24'd1 << cw) - 1));
    row = 10'(a >> (cw + 1));
    return {row[5:0], col};
  endfunction

  task automatic access(input logic [23:0] a, input logic we, input logic [1:0] be,
                        input logic [15:0] wd, output int lat, output logic [15:0] rd);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_we = we; req_be = be; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
      if (lat == 1) req_valid = 1'b0;
    end while (!done && lat < 50);
    rd = rd_data;
  endtask

  localparam logic [23:0] A0 = 24'h4A_B5C6;   // area 2

  task automatic t_reset();
    @(negedge clk);
    chk("R10 reset ras_n", ras_n, 1);
    chk("R10 reset cas", {ucas_n, lcas_n}, 2'b11);
    chk("R10 reset we_n/oe/done", {we_n, dq_oe, done}, 3'b100);
    chk("R10 reset ready", req_ready, 1);
  endtask

  task automatic t_closed_read();
    int lat, f0; logic [15:0] rd;
    f0 = ras_fall;
    access(A0, 1'b0, 2'b11, '0, lat, rd);
    chk("R4 closed-page latency", lat, 3);
    chk("R2 R4 read data mux sel0", rd, exp_rd(A0, 0));
    chk("R4 one row open", ras_fall - f0, 1);
    @(negedge clk);
    chk("R4 done single", done, 0);
  endtask

  task automatic t_page_hit();
    int lat, f0, r0; logic [15:0] rd;
    f0 = ras_fall; r0 = ras_rise;
    access(A0 ^ 24'h1C, 1'b0, 2'b11, '0, lat, rd);
    chk("R5 page-hit latency", lat, 2);
    chk("R5 page-hit data", rd, exp_rd(A0 ^ 24'h1C, 0));
    chk("R5 no new row / precharge", (ras_fall - f0) + (ras_rise - r0), 0);
  endtask

  task automatic t_write_bytes();
    int lat; logic [15:0] rd;
    wr_seen = 1'b0;
    access(A0 ^ 24'h08, 1'b1, 2'b01, 16'hC3A5, lat, rd);
    chk("R3 write seen", wr_seen, 1);
    chk("R3 write data", wr_data, 16'hC3A5);
    chk("R3 lane be=01", {wr_u, wr_l}, 2'b01);
    wr_seen = 1'b0;
    access(A0 ^ 24'h10, 1'b1, 2'b10, 16'h5A0F, lat, rd);
    chk("R3 lane be=10", {wr_u, wr_l}, 2'b10);
    chk("R3 write data 2", wr_data, 16'h5A0F);
    chk("R5 write page hit latency", lat, 2);
  endtask

  task automatic t_miss();
    int lat, f0, r0; logic [15:0] rd;
    f0 = ras_fall; r0 = ras_rise;
    access(A0 ^ 24'h00_4000, 1'b0, 2'b11, '0, lat, rd);
    chk("R6 row-miss latency", lat, 4);
    chk("R6 precharge then new row", {ras_rise - r0, ras_fall - f0}, {32'd1, 32'd1});
    chk("R6 row-miss data", rd, exp_rd(A0 ^ 24'h00_4000, 0));
    access(A0 ^ 24'h20_4000, 1'b0, 2'b11, '0, lat, rd);   // area 3, same row bits
    chk("R6 other-area latency", lat, 4);
  endtask

  task automatic t_non_dram();
    int lat, f0, r0; logic [15:0] rd;
    f0 = ras_fall; r0 = ras_rise;
    access(24'h0A_B5C6, 1'b0, 2'b11, '0, lat, rd);
    chk("R1 area0 done latency", lat, 1);
    access(24'h8A_B5C6, 1'b1, 2'b11, 16'h1234, lat, rd);  // area 4 disabled
    chk("R1 disabled area latency", lat, 1);
    chk("R1 no strobe movement", (ras_fall - f0) + (ras_rise - r0), 0);
  endtask

  task automatic t_colwidth();
    int lat; logic [15:0] rd;
    col_sel = 2'd1;
    access(24'hAA_B5C6, 1'b0, 2'b11, '0, lat, rd);          // area 5
    chk("R2 col width 9", rd, exp_rd(24'hAA_B5C6, 1));
    col_sel = 2'd2;
    access(A0, 1'b0, 2'b11, '0, lat, rd);
    chk("R2 col width 10", rd, exp_rd(A0, 2));
    col_sel = 2'd0;
  endtask

  task automatic t_cbr();
    int c0, n, lat; logic [15:0] rd;
    c0 = cbr_cnt; n = 0;
    refr_interval = 12'd30;
    while (cbr_cnt == c0 && n < 200) begin @(negedge clk); n++; end
    refr_interval = '0;
    chk("R8 periodic refresh happened", cbr_cnt - c0, 1);
    chk("R7 cas before ras", cbr_bad, 0);
    @(negedge clk);
    chk("R7 closing precharge", {ras_n, ucas_n, lcas_n}, 3'b111);
    access(A0, 1'b0, 2'b11, '0, lat, rd);
    chk("R7 row closed after refresh", lat, 3);
    c0 = cbr_cnt;
    repeat (150) @(negedge clk);
    chk("R8 interval 0 disables refresh", cbr_cnt - c0, 0);
  endtask

  task automatic t_refresh_priority();
    int c0, lat, bad; logic [15:0] rd;
    c0 = cbr_cnt; bad = 0;
    refr_interval = 12'd9;
    for (int i = 0; i < 12; i++) begin
      access(A0 ^ 24'(i << 1), 1'b0, 2'b11, '0, lat, rd);
      if (rd != exp_rd(A0 ^ 24'(i << 1), 0)) bad++;
    end
    refr_interval = '0;
    chk("R8 refresh served among held requests", (cbr_cnt - c0) > 0, 1);
    chk("R8 data intact around refresh", bad, 0);
    chk("R7 strobe order kept", cbr_bad, 0);
  endtask

  task automatic t_selfref();
    int lat; logic [15:0] rd;
    access(A0, 1'b0, 2'b11, '0, lat, rd);   // leave a row open
    @(negedge clk);
    selfref_req = 1'b1;
    req_valid = 1'b1; req_addr = A0;
    repeat (8) @(negedge clk);
    chk("R9 strobes held low", {ras_n, ucas_n, lcas_n}, 3'b000);
    chk("R9 ready low in self-refresh", req_ready, 0);
    chk("R9 no done in self-refresh", done, 0);
    req_valid = 1'b0;
    selfref_req = 1'b0;
    @(negedge clk);
    chk("R9 exit precharge", {ras_n, ucas_n, lcas_n, req_ready}, 4'b1110);
    @(negedge clk);
    chk("R9 idle after exit", {ras_n, req_ready}, 2'b11);
    access(A0, 1'b0, 2'b11, '0, lat, rd);
    chk("R9 row closed after exit", lat, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_closed_read();
    t_page_hit();
    t_write_bytes();
    t_miss();
    t_non_dram();
    t_colwidth();
    t_cbr();
    t_refresh_priority();
    t_selfref();
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule